// File: doc/BRIEF.md
# Capture / Compare / PWM Timer Channel

This block is a single timer channel that sits beside a shared free-running or up/down counter. It does not own the counter: it receives the count, the counting direction and a one-cycle period-boundary strobe, and it uses them in one of three modes. In capture mode it synchronises an external pin, detects the edges selected for it, and stores the count at which the edge arrived. In compare mode it watches for the count to equal its value register and then sets, clears or toggles its output pin. In PWM mode it drives an edge-aligned or center-aligned waveform whose duty value is double-buffered, so that a new duty takes effect only at a period boundary.

Each event raises a sticky channel flag, which software clears by writing a one. The channel interrupt is that flag gated by an enable. One `cfg_sel` field is shared: it picks the capture edge in capture mode and the pin action in compare mode.

Top module: `tcc_channel`

## Requirements
- R1: During and after reset, before any stimulus, `pin_out`, `pin_oe`, `chan_flag`, `chan_irq` and `chan_val` are all zero.
- R2: In capture mode (`cfg_mode`=00), a selected transition of `pin_in` passes through two synchronising flip-flops. `chan_val` then takes the `cnt_val` present at the third rising clock edge after the pin change, and `chan_flag` rises at that same edge and not before.
- R3: In capture mode, `cfg_sel` picks the trigger: 00 means no edge, 01 rising, 10 falling, 11 either. A transition that is not selected changes neither `chan_val` nor `chan_flag`.
- R4: In compare mode (`cfg_mode`=01), at the clock edge where `cnt_val` equals `chan_val`, the pin acts according to `cfg_sel`: 01 toggles, 10 clears, 11 sets, and 00 leaves it unchanged. The pin holds its value at all other edges.
- R5: `chan_flag` is set by a capture event in capture mode, by a count match with the value register in compare mode, and by a count match with the active duty in PWM mode.
- R6: A cycle with `flag_clr` high and no new event clears `chan_flag`. A new event in the same cycle as `flag_clr` leaves the flag set.
- R7: `chan_irq` equals `chan_flag` AND `irq_en`.
- R8: In edge-aligned PWM (`cfg_mode`=10, `cfg_center`=0, high-true), the pin after a clock edge at count c is 1 exactly when c is below the active duty. So duty 0 gives a constant low, and a duty above the terminal count gives a constant high.
- R9: In center-aligned PWM (`cfg_center`=1), the pin after an edge at count c is 1 when c is below the duty while counting up (`cnt_down`=0), and when c is at or below the duty while counting down. The pin therefore falls on the up-count match and rises on the down-count match.
- R10: `cfg_low_true`=1 inverts the PWM pin level of R8 and R9.
- R11: In PWM mode, a write changes `chan_val` at once, but the active duty is loaded from it only at an edge where `cnt_tc` is high. Outside PWM mode, the active duty follows `chan_val` on every cycle.
- R12: `pin_oe` is 1 in PWM mode and in compare mode with a nonzero `cfg_sel`, and 0 otherwise. Mode 11 is idle: the pin is held and no flag is raised, even on a count match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | CNT_W | Shared counter value |
| cnt_down | input | 1 | Counter will decrement next (up/down operation) |
| cnt_tc | input | 1 | Period boundary strobe |
| cfg_mode | input | 2 | 00 capture, 01 compare, 10 PWM, 11 idle |
| cfg_sel | input | 2 | Capture edge or compare pin action |
| cfg_center | input | 1 | Center-aligned PWM timing |
| cfg_low_true | input | 1 | Inverted PWM polarity |
| irq_en | input | 1 | Channel interrupt enable |
| val_wr | input | 1 | Write strobe for the value register |
| val_wdata | input | CNT_W | Write data for the value register |
| flag_clr | input | 1 | Write-one-to-clear of the flag |
| pin_in | input | 1 | Asynchronous capture pin |
| pin_out | output | 1 | Channel pin drive |
| pin_oe | output | 1 | Channel pin output enable |
| chan_val | output | CNT_W | Value register (capture, compare or duty buffer) |
| chan_flag | output | 1 | Sticky channel event flag |
| chan_irq | output | 1 | Channel interrupt |

## Verification
The embedded assertions check, on every cycle, the relations that need only one edge of history. These are: the flag rising after any event and falling after a lone clear; a capture storing the count it saw; the set and clear pin actions on a compare hit; the active duty staying frozen between period boundaries in PWM; the output enable staying low in capture mode; and the single-cycle width of a rising-edge strobe. The whole waveform shape is left to the bench scenarios. Those scenarios cover the PWM level at every count of a period for every duty, polarity and alignment, the three-edge capture latency, the skipped edges, and the mid-period duty write that must wait for the next boundary.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

  typedef enum logic [1:0] {
    MODE_CAP  = 2'b00,
    MODE_CMP  = 2'b01,
    MODE_PWM  = 2'b10,
    MODE_IDLE = 2'b11
  } tcc_mode_e;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } tcc_act_e;

endpackage

// File: rtl/tcc_in_edge.sv
module tcc_in_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_in,
  input  logic [1:0] edge_sel,
  output logic       edge_evt
);

  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] sh_q, sh_d;
  logic            rise, fall;

  always_comb begin
    sh_d = {sh_q[SH_W-2:0], pin_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise     = sh_q[SH_W-2] & ~sh_q[SH_W-1];
  assign fall     = ~sh_q[SH_W-2] & sh_q[SH_W-1];
  assign edge_evt = (edge_sel[0] & rise) | (edge_sel[1] & fall);

  // R2
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/tcc_duty_buf.sv
module tcc_duty_buf #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_on,
  input  logic             cnt_tc,
  input  logic [CNT_W-1:0] val_q,
  output logic [CNT_W-1:0] duty_q
);

  logic [CNT_W-1:0] duty_d;
  logic             load_en;

  assign load_en = !pwm_on || cnt_tc;

  always_comb begin
    duty_d = duty_q;
    if (load_en) duty_d = val_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) duty_q <= '0;
    else        duty_q <= duty_d;
  end

  // R11
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_on && !cnt_tc) |=> $stable(duty_q));

endmodule

// File: rtl/tcc_out_ctl.sv
module tcc_out_ctl
  import tcc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tcc_mode_e        mode,
  input  logic [1:0]       sel,
  input  logic             center,
  input  logic             low_true,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_down,
  input  logic [CNT_W-1:0] val_q,
  input  logic [CNT_W-1:0] duty_q,
  output logic             pin_q,
  output logic             pin_oe,
  output logic             match
);

  logic     pin_d;
  logic     cmp_hit, duty_hit;
  logic     lvl_up, lvl_dn, pwm_lvl;
  tcc_act_e act;

  assign act      = tcc_act_e'(sel);
  assign cmp_hit  = (cnt_val == val_q);
  assign duty_hit = (cnt_val == duty_q);
  assign lvl_up   = (cnt_val < duty_q);
  assign lvl_dn   = (cnt_val <= duty_q);

  always_comb begin
    if (center && cnt_down) pwm_lvl = lvl_dn;
    else                    pwm_lvl = lvl_up;
  end

  always_comb begin
    pin_d = pin_q;
    case (mode)
      MODE_CMP: begin
        if (cmp_hit) begin
          case (act)
            ACT_TOGGLE: pin_d = ~pin_q;
            ACT_CLEAR:  pin_d = 1'b0;
            ACT_SET:    pin_d = 1'b1;
            default:    pin_d = pin_q;
          endcase
        end
      end
      MODE_PWM: pin_d = pwm_lvl ^ low_true;
      default:  pin_d = pin_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_d;
  end

  always_comb begin
    pin_oe = 1'b0;
    match  = 1'b0;
    case (mode)
      MODE_CMP: begin
        pin_oe = (act != ACT_NONE);
        match  = cmp_hit;
      end
      MODE_PWM: begin
        pin_oe = 1'b1;
        match  = duty_hit;
      end
      default: begin
        pin_oe = 1'b0;
        match  = 1'b0;
      end
    endcase
  end

  // R4
  cmp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_CMP && act == ACT_SET && cnt_val == val_q) |=> pin_q);

  // R4
  cmp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_CMP && act == ACT_CLEAR && cnt_val == val_q) |=> !pin_q);

  // R12
  cap_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_CAP) |-> !pin_oe);

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_IDLE) |=> $stable(pin_q));

endmodule

// File: rtl/tcc_channel.sv
module tcc_channel
  import tcc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_down,
  input  logic             cnt_tc,
  input  logic [1:0]       cfg_mode,
  input  logic [1:0]       cfg_sel,
  input  logic             cfg_center,
  input  logic             cfg_low_true,
  input  logic             irq_en,
  input  logic             val_wr,
  input  logic [CNT_W-1:0] val_wdata,
  input  logic             flag_clr,
  input  logic             pin_in,
  output logic             pin_out,
  output logic             pin_oe,
  output logic [CNT_W-1:0] chan_val,
  output logic             chan_flag,
  output logic             chan_irq
);

  tcc_mode_e        mode;
  logic [CNT_W-1:0] val_q, val_d;
  logic [CNT_W-1:0] duty_q;
  logic             edge_evt, cap_evt, match, set_evt;
  logic             flag_q, flag_d;
  logic             pwm_on;

  assign mode   = tcc_mode_e'(cfg_mode);
  assign pwm_on = (mode == MODE_PWM);

  tcc_in_edge #(
    .SYNC_STAGES(SYNC_STAGES)
  ) i_in_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_in   (pin_in),
    .edge_sel (cfg_sel),
    .edge_evt (edge_evt)
  );

  tcc_duty_buf #(
    .CNT_W(CNT_W)
  ) i_duty_buf (
    .clk    (clk),
    .rst_n  (rst_n),
    .pwm_on (pwm_on),
    .cnt_tc (cnt_tc),
    .val_q  (val_q),
    .duty_q (duty_q)
  );

  tcc_out_ctl #(
    .CNT_W(CNT_W)
  ) i_out_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .sel      (cfg_sel),
    .center   (cfg_center),
    .low_true (cfg_low_true),
    .cnt_val  (cnt_val),
    .cnt_down (cnt_down),
    .val_q    (val_q),
    .duty_q   (duty_q),
    .pin_q    (pin_out),
    .pin_oe   (pin_oe),
    .match    (match)
  );

  assign cap_evt = (mode == MODE_CAP) && edge_evt;
  assign set_evt = cap_evt || match;

  always_comb begin
    val_d = val_q;
    if (cap_evt)     val_d = cnt_val;
    else if (val_wr) val_d = val_wdata;
  end

  always_comb begin
    flag_d = flag_q;
    if (flag_clr) flag_d = 1'b0;
    if (set_evt)  flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      val_q  <= val_d;
      flag_q <= flag_d;
    end
  end

  assign chan_val  = val_q;
  assign chan_flag = flag_q;
  assign chan_irq  = flag_q & irq_en;

  // R5
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> chan_flag);

  // R6
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !set_evt) |=> !chan_flag);

  // R2
  cap_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (chan_val == $past(cnt_val)));

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_flag |-> !chan_irq);

endmodule

// File: tb/test_tcc_channel.sv
`timescale 1ns/1ps
module test_tcc_channel;

  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] cnt_val;
  logic          cnt_down, cnt_tc;
  logic [1:0]    cfg_mode, cfg_sel;
  logic          cfg_center, cfg_low_true, irq_en;
  logic          val_wr;
  logic [CW-1:0] val_wdata;
  logic          flag_clr, pin_in;
  logic          pin_out, pin_oe, chan_flag, chan_irq;
  logic [CW-1:0] chan_val;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  int  mod_m  = 65535;
  bit  ctr_ud = 0;
  int  c      = 0;
  bit  dn     = 0;
  int  pc     = 0;
  bit  pdn    = 0;

  always #4 clk = ~clk;

  tcc_channel #(.CNT_W(CW)) i_tcc_channel (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_down(cnt_down),
    .cnt_tc(cnt_tc), .cfg_mode(cfg_mode), .cfg_sel(cfg_sel),
    .cfg_center(cfg_center), .cfg_low_true(cfg_low_true), .irq_en(irq_en),
    .val_wr(val_wr), .val_wdata(val_wdata), .flag_clr(flag_clr),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .chan_val(chan_val), .chan_flag(chan_flag), .chan_irq(chan_irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive_ctr();
    cnt_val  = CW'(c);
    cnt_down = dn;
    cnt_tc   = (c == mod_m);
  endtask

  task automatic set_ctr(input int v, input bit d);
    c  = v;
    dn = d;
    drive_ctr();
  endtask

  // one clock: record counter seen at the edge, then advance it
  task automatic cyc();
    pc  = c;
    pdn = dn;
    @(posedge clk);
    @(negedge clk);
    if (!ctr_ud) begin
      c  = (c >= mod_m) ? 0 : c + 1;
      dn = 0;
    end else if (!dn) begin
      c = c + 1;
      if (c >= mod_m) dn = 1;
    end else begin
      c = c - 1;
      if (c <= 0) dn = 0;
    end
    drive_ctr();
  endtask

  function automatic bit pwm_exp(input int cv, input bit d, input int duty,
                                 input bit ctr, input bit lt);
    bit lv;
    if (ctr && d) lv = (cv <= duty);
    else          lv = (cv < duty);
    return lv ^ lt;
  endfunction

  task automatic cap_case(input logic [1:0] sel, input bit rising);
    int  c0;
    int  v0;
    bit  hit;
    cfg_mode = 2'b00;
    cfg_sel  = sel;
    pin_in   = rising ? 1'b0 : 1'b1;
    repeat (4) cyc();
    flag_clr = 1'b1; cyc(); flag_clr = 1'b0; cyc();
    v0  = int'(chan_val);
    c0  = c;
    hit = rising ? sel[0] : sel[1];
    pin_in = rising;
    cyc(); cyc();
    chk(chan_flag == 1'b0, "R2 latency", int'(chan_flag), 0);
    cyc();
    chk(chan_flag == hit, "R3 edge select flag", int'(chan_flag), int'(hit));
    chk(int'(chan_val) == (hit ? c0 + 2 : v0), "R2 captured value",
        int'(chan_val), hit ? c0 + 2 : v0);
    chk(pin_oe == 1'b0, "R12 capture oe", int'(pin_oe), 0);
  endtask

  initial begin : watchdog
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    bit exp_pin;
    rst_n = 1'b0; cfg_mode = 2'b00; cfg_sel = 2'b00; cfg_center = 1'b0;
    cfg_low_true = 1'b0; irq_en = 1'b0; val_wr = 1'b0; val_wdata = '0;
    flag_clr = 1'b0; pin_in = 1'b0;
    set_ctr(0, 0);
    repeat (3) @(negedge clk);
    chk({pin_out, pin_oe, chan_flag, chan_irq} == 4'b0, "R1 reset outputs",
        int'({pin_out, pin_oe, chan_flag, chan_irq}), 0);
    chk(chan_val == '0, "R1 reset value", int'(chan_val), 0);
    rst_n = 1'b1;
    cyc();
    chk({pin_out, pin_oe, chan_flag} == 3'b0, "R1 after release",
        int'({pin_out, pin_oe, chan_flag}), 0);

    // capture sweep: all selections, both transitions
    mod_m = 65535; ctr_ud = 0; set_ctr(10, 0);
    for (int s = 0; s < 4; s++) begin
      cap_case(2'(s), 1'b1);
      cap_case(2'(s), 1'b0);
    end

    // compare: set, toggle, toggle, clear, none
    cfg_sel = 2'b00; cfg_mode = 2'b01; set_ctr(100, 0);
    val_wr = 1'b1; val_wdata = CW'(5); cyc(); val_wr = 1'b0;
    exp_pin = 1'b0;
    for (int k = 0; k < 5; k++) begin
      logic [1:0] a;
      case (k)
        0: a = 2'b11;
        1: a = 2'b01;
        2: a = 2'b01;
        3: a = 2'b10;
        default: a = 2'b00;
      endcase
      cfg_sel = a;
      set_ctr(0, 0);
      flag_clr = 1'b1; cyc(); flag_clr = 1'b0;
      while (pc != 5) begin
        cyc();
        if (pc == 4) begin
          chk(pin_out == exp_pin, "R4 hold before match", int'(pin_out), int'(exp_pin));
          chk(chan_flag == 1'b0, "R5 no flag before match", int'(chan_flag), 0);
        end
      end
      case (a)
        2'b01: exp_pin = ~exp_pin;
        2'b10: exp_pin = 1'b0;
        2'b11: exp_pin = 1'b1;
        default: exp_pin = exp_pin;
      endcase
      chk(pin_out == exp_pin, "R4 compare action", int'(pin_out), int'(exp_pin));
      chk(chan_flag == 1'b1, "R5 compare flag", int'(chan_flag), 1);
      chk(pin_oe == (a != 2'b00), "R12 compare oe", int'(pin_oe), int'(a != 2'b00));
    end

    // flag clear collision and interrupt gating
    cfg_sel = 2'b00; set_ctr(4, 0);
    cyc();
    flag_clr = 1'b1; cyc(); flag_clr = 1'b0;
    chk(chan_flag == 1'b1, "R6 set wins over clear", int'(chan_flag), 1);
    chk(chan_irq == 1'b0, "R7 irq masked", int'(chan_irq), 0);
    irq_en = 1'b1; #1;
    chk(chan_irq == 1'b1, "R7 irq enabled", int'(chan_irq), 1);
    flag_clr = 1'b1; cyc(); flag_clr = 1'b0;
    chk(chan_flag == 1'b0, "R6 clear", int'(chan_flag), 0);
    chk(chan_irq == 1'b0, "R7 irq follows flag", int'(chan_irq), 0);
    irq_en = 1'b0;

    // idle mode: match ignored
    cfg_mode = 2'b11; cfg_sel = 2'b11; set_ctr(4, 0);
    exp_pin = pin_out;
    cyc(); cyc();
    chk(chan_flag == 1'b0, "R12 idle no flag", int'(chan_flag), 0);
    chk(pin_out == exp_pin && pin_oe == 1'b0, "R12 idle pin",
        int'({pin_oe, pin_out}), int'({1'b0, exp_pin}));

    // PWM sweep
    mod_m = 7;
    for (int ctr = 0; ctr < 2; ctr++) begin
      for (int lt = 0; lt < 2; lt++) begin
        for (int d = 0; d < 10; d++) begin
          int per;
          ctr_ud = ctr[0]; cfg_center = ctr[0]; cfg_low_true = lt[0];
          cfg_mode = 2'b10;
          per = ctr_ud ? 2 * mod_m : mod_m + 1;
          set_ctr(0, 0);
          val_wr = 1'b1; val_wdata = CW'(d); cyc(); val_wr = 1'b0;
          repeat (per - 1) cyc();
          for (int k = 0; k < per; k++) begin
            bit e;
            cyc();
            e = pwm_exp(pc, pdn, d, ctr[0], lt[0]);
            chk(pin_out == e, ctr ? "R9 center level (R10)" : "R8 edge level (R10)",
                int'(pin_out), int'(e));
          end
          chk(pin_oe == 1'b1, "R12 pwm oe", int'(pin_oe), 1);
        end
      end
    end

    // buffered duty: mid-period write waits for the boundary
    ctr_ud = 0; cfg_center = 1'b0; cfg_low_true = 1'b0; cfg_mode = 2'b10;
    set_ctr(0, 0);
    val_wr = 1'b1; val_wdata = CW'(3); cyc(); val_wr = 1'b0;
    repeat (7) cyc();
    cyc();
    val_wr = 1'b1; val_wdata = CW'(6); cyc(); val_wr = 1'b0;
    chk(int'(chan_val) == 6, "R11 buffer written", int'(chan_val), 6);
    while (pc != 4) cyc();
    chk(pin_out == 1'b0, "R11 old duty kept", int'(pin_out), 0);
    while (pc != 0) cyc();
    while (pc != 4) cyc();
    chk(pin_out == 1'b1, "R11 new duty at boundary", int'(pin_out), 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule